// File: doc/BRIEF.md
# Serial Attenuation Word Programmer

This block sits on the host side of a digital step attenuator. It drives the attenuator's three-wire serial control port. A request gives the wanted attenuation as a count of half-dB steps together with a one-cycle start strobe. The block turns the count into an 8-bit attenuation word that represents four times the dB value. It shifts the word out least significant bit first on a data line and a serial clock line, then pulses the latch line to transfer the word into the attenuator core. A one-cycle done pulse closes each transfer. The serial/parallel select output stays high, so the attenuator remains in serial mode.

Every interface phase comes from a down-counter running on the system clock. The serial clock high time, the serial clock low time, the latch setup time and the latch pulse width are each given in picoseconds as parameters. Each one is converted to system clock cycles and rounded up. The high phase also covers the data hold time, and the low phase also covers the data setup time. While a transfer runs, the busy output is high and any further start strobe is ignored.

The control state machine has six states:
- IDLE waits for start. START_ACCEPT moves it to BIT_LOW.
- BIT_LOW drives the current bit with the serial clock low. When the timer expires it moves to BIT_HIGH.
- BIT_HIGH raises the serial clock. When the timer expires it goes to BIT_LOW through NEXT_BIT, or to LATCH_SETUP through LAST_BIT.
- LATCH_SETUP waits with both the serial clock and the latch line low. When the timer expires it moves to LATCH_PULSE.
- LATCH_PULSE holds the latch line high. When the timer expires it moves to FINISH.
- FINISH asserts done for one cycle and always returns to IDLE.

Top module: `atten_serial_prog`

## Requirements
- R1: The word sent has bits 6..1 equal to the 6-bit request and bits 7 and 0 equal to 0. For example, request 25 (12.5 dB) sends 50 (8'b0011_0010).
- R2: Each transfer has exactly 8 serial clock rising edges. The bit on the data line at each rising edge is the next word bit, starting with bit 0.
- R3: The latch line is low whenever the serial clock is high and at every serial clock rising edge.
- R4: Each accepted request produces exactly one latch pulse (low, high, low), and it comes after the eighth rising edge.
- R5: Each serial clock high phase lasts exactly HIGH_CYC = ceil(max(high time, hold time) / clock period) cycles. Each low phase before a rising edge lasts exactly LOW_CYC = ceil(max(low time, setup time) / clock period) cycles. With the default parameters both are 7 cycles (56 ns), which gives a serial clock of at most 10 MHz.
- R6: The latch line rises exactly HIGH_CYC + LSU_CYC cycles after the last rising edge, where LSU_CYC = ceil(latch setup / period). It stays high for exactly LEW_CYC = ceil(latch width / period) cycles, which is at least 30 ns.
- R7: The data line is stable for at least ceil(setup / period) cycles before each rising edge and does not change while the serial clock is high.
- R8: done is high for exactly one cycle: the cycle in which the latch line first reads low again.
- R9: busy is high from the cycle after start is sampled up to and including the done cycle, for 8*(LOW_CYC+HIGH_CYC)+LSU_CYC+LEW_CYC+1 cycles. A start strobe while busy is ignored.
- R10: While reset and while idle, the serial clock, latch line, data line, busy and done are low. The serial/parallel select output is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe, sampled only when idle |
| atten_req | input | 6 | Requested attenuation in half-dB steps (0..63) |
| atten_sdata | output | 1 | Serial data to the attenuator |
| atten_sclk | output | 1 | Serial clock to the attenuator |
| atten_latch | output | 1 | Latch line to the attenuator |
| serial_sel | output | 1 | Serial/parallel select, held high for serial mode |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The outputs are decoded from registered state, so each result is visible in the cycle after the edge that causes it.
- busy reads high in the first sample after the strobe.
- The first rising edge comes LOW_CYC cycles later, and later edges come every LOW_CYC+HIGH_CYC cycles.
- The latch line rises HIGH_CYC+LSU_CYC cycles after the eighth rising edge.
- done coincides with the first low sample of the latch line.

The bench samples every output on the falling system clock edge and measures each phase length by counting samples. It compares those counts to exact values that it computes from the timing parameters with its own rounding functions. A model of the attenuator's shift register captures the data bit at each rising edge and freezes the word when the latch line rises. That frozen word is compared with the request shifted left by one.

// File: rtl/atten_prog_pkg.sv
`timescale 1ns/1ps
package atten_prog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BIT_LOW,
        ST_BIT_HIGH,
        ST_LATCH_SETUP,
        ST_LATCH_PULSE,
        ST_FINISH
    } prog_state_t;

    // Convert a duration to whole system cycles, rounded up, at least one.
    function automatic int ps_to_cycles(input int dur_ps, input int clk_ps);
        int c;
        c = (dur_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/atten_word_builder.sv
`timescale 1ns/1ps
module atten_word_builder #(
    parameter int REQ_W = 6,
    localparam int WORD_W = REQ_W + 2
) (
    input  logic [REQ_W-1:0]  req_steps,
    output logic [WORD_W-1:0] word
);
    // Half-dB count times two gives quarter-dB units: bit 0 unused, top bit free.
    assign word[0]        = 1'b0;
    assign word[WORD_W-1] = 1'b0;

    for (genvar i = 0; i < REQ_W; i++) begin : g_map
        assign word[i+1] = req_steps[i];
    end
endmodule

// File: rtl/atten_phase_timer.sv
`timescale 1ns/1ps
module atten_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/atten_bit_shifter.sv
`timescale 1ns/1ps
module atten_bit_shifter #(
    parameter int WORD_W = 8,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] word_in,
    output logic              cur_bit,
    output logic              last_bit
);
    logic [WORD_W-1:0] sreg_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            sreg_q <= word_in;
            idx_q  <= '0;
        end else if (shift) begin
            sreg_q <= {1'b0, sreg_q[WORD_W-1:1]};
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign cur_bit  = sreg_q[0];
    assign last_bit = (idx_q == IDX_W'(WORD_W - 1));
endmodule

// File: rtl/atten_prog_fsm.sv
`timescale 1ns/1ps
module atten_prog_fsm
    import atten_prog_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int HIGH_CYC = 7,
    parameter int LOW_CYC  = 7,
    parameter int LSU_CYC  = 2,
    parameter int LEW_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             timer_expired,
    input  logic             last_bit,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             word_load,
    output logic             word_shift,
    output logic             data_en,
    output logic             sclk,
    output logic             latch,
    output logic             busy,
    output logic             done
);
    localparam logic [CNT_W-1:0] HIGH_LD = CNT_W'(HIGH_CYC - 1);
    localparam logic [CNT_W-1:0] LOW_LD  = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0] LSU_LD  = CNT_W'(LSU_CYC - 1);
    localparam logic [CNT_W-1:0] LEW_LD  = CNT_W'(LEW_CYC - 1);

    prog_state_t state_q, state_d;

    // Next state and datapath controls.
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        word_load  = 1'b0;
        word_shift = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d    = ST_BIT_LOW;
                    timer_load = 1'b1;
                    timer_val  = LOW_LD;
                    word_load  = 1'b1;
                end
            end
            ST_BIT_LOW: begin
                if (timer_expired) begin
                    state_d    = ST_BIT_HIGH;
                    timer_load = 1'b1;
                    timer_val  = HIGH_LD;
                end
            end
            ST_BIT_HIGH: begin
                if (timer_expired) begin
                    timer_load = 1'b1;
                    if (last_bit) begin
                        state_d   = ST_LATCH_SETUP;
                        timer_val = LSU_LD;
                    end else begin
                        state_d    = ST_BIT_LOW;
                        timer_val  = LOW_LD;
                        word_shift = 1'b1;
                    end
                end
            end
            ST_LATCH_SETUP: begin
                if (timer_expired) begin
                    state_d    = ST_LATCH_PULSE;
                    timer_load = 1'b1;
                    timer_val  = LEW_LD;
                end
            end
            ST_LATCH_PULSE: begin
                if (timer_expired) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode (Moore).
    always_comb begin
        data_en = 1'b0;
        sclk    = 1'b0;
        latch   = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:        busy = 1'b0;
            ST_BIT_LOW:     data_en = 1'b1;
            ST_BIT_HIGH:    begin data_en = 1'b1; sclk = 1'b1; end
            ST_LATCH_SETUP: data_en = 1'b1;
            ST_LATCH_PULSE: latch = 1'b1;
            ST_FINISH:      done = 1'b1;
            default:        busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/atten_serial_prog.sv
`timescale 1ns/1ps
module atten_serial_prog
    import atten_prog_pkg::*;
#(
    parameter int REQ_W          = 6,
    parameter int SYS_CLK_PS     = 8000,
    parameter int SCLK_HIGH_PS   = 50000,
    parameter int SCLK_LOW_PS    = 50000,
    parameter int DATA_SETUP_PS  = 10000,
    parameter int DATA_HOLD_PS   = 10000,
    parameter int LATCH_SETUP_PS = 10000,
    parameter int LATCH_WIDTH_PS = 30000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REQ_W-1:0] atten_req,
    output logic             atten_sdata,
    output logic             atten_sclk,
    output logic             atten_latch,
    output logic             serial_sel,
    output logic             busy,
    output logic             done
);
    localparam int WORD_W   = REQ_W + 2;
    localparam int HIGH_CYC = ps_to_cycles(max_of(SCLK_HIGH_PS, DATA_HOLD_PS), SYS_CLK_PS);
    localparam int LOW_CYC  = ps_to_cycles(max_of(SCLK_LOW_PS, DATA_SETUP_PS), SYS_CLK_PS);
    localparam int LSU_CYC  = ps_to_cycles(LATCH_SETUP_PS, SYS_CLK_PS);
    localparam int LEW_CYC  = ps_to_cycles(LATCH_WIDTH_PS, SYS_CLK_PS);
    localparam int MAX_CYC  = max_of(max_of(HIGH_CYC, LOW_CYC), max_of(LSU_CYC, LEW_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  timer_val;
    logic timer_load, timer_expired;
    logic word_load, word_shift, cur_bit, last_bit, data_en;

    atten_word_builder #(.REQ_W(REQ_W)) u_word (
        .req_steps (atten_req),
        .word      (word)
    );

    atten_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_expired)
    );

    atten_bit_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (word_load),
        .shift    (word_shift),
        .word_in  (word),
        .cur_bit  (cur_bit),
        .last_bit (last_bit)
    );

    atten_prog_fsm #(
        .CNT_W    (CNT_W),
        .HIGH_CYC (HIGH_CYC),
        .LOW_CYC  (LOW_CYC),
        .LSU_CYC  (LSU_CYC),
        .LEW_CYC  (LEW_CYC)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .timer_expired (timer_expired),
        .last_bit      (last_bit),
        .timer_load    (timer_load),
        .timer_val     (timer_val),
        .word_load     (word_load),
        .word_shift    (word_shift),
        .data_en       (data_en),
        .sclk          (atten_sclk),
        .latch         (atten_latch),
        .busy          (busy),
        .done          (done)
    );

    assign atten_sdata = data_en & cur_bit;
    assign serial_sel  = 1'b1;
endmodule

// File: rtl/atten_prog_checker.sv
`timescale 1ns/1ps
module atten_prog_checker #(
    parameter int HIGH_CYC = 7
) (
    input logic clk,
    input logic rst_n,
    input logic ser_clk,
    input logic ser_data,
    input logic latch,
    input logic busy,
    input logic done
);
    logic [15:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_run <= '0;
        else        hi_run <= ser_clk ? hi_run + 16'd1 : 16'd0;
    end

    assert_latch_low_sclk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> !latch);
    assert_latch_rise_sclk_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch) |-> !ser_clk);
    assert_high_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk) |-> (hi_run >= 16'(HIGH_CYC)));
    assert_data_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_data));
    assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_on_latch_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch) |-> done);
    assert_busy_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_clk && !latch && !ser_data && !done));
endmodule

bind atten_serial_prog atten_prog_checker #(.HIGH_CYC(HIGH_CYC)) u_prog_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (atten_sclk),
    .ser_data (atten_sdata),
    .latch    (atten_latch),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_atten_serial_prog.sv
`timescale 1ns/1ps
module tb_atten_serial_prog;
    localparam int CLK_PS = 8000;

    function automatic int cyc(input int t_ps);
        int c;
        c = t_ps / CLK_PS;
        if (c * CLK_PS < t_ps) c = c + 1;
        if (c < 1) c = 1;
        return c;
    endfunction

    // Defaults: high/low 50 ns, setup/hold 10 ns, latch setup 10 ns, latch width 30 ns.
    localparam int E_HIGH  = cyc(50000);
    localparam int E_LOW   = cyc(50000);
    localparam int E_SETUP = cyc(10000);
    localparam int E_LSU   = cyc(10000);
    localparam int E_LEW   = cyc(30000);
    localparam int E_XFER  = 8 * (E_LOW + E_HIGH) + E_LSU + E_LEW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [5:0] atten_req = '0;
    logic atten_sdata, atten_sclk, atten_latch, serial_sel, busy, done;

    always #4 clk = ~clk;

    atten_serial_prog dut (
        .clk(clk), .rst_n(rst_n), .start(start), .atten_req(atten_req),
        .atten_sdata(atten_sdata), .atten_sclk(atten_sclk), .atten_latch(atten_latch),
        .serial_sel(serial_sel), .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_word(input logic [5:0] r);
        return {1'b0, r, 1'b0};
    endfunction

    // Monitor: attenuator-side model sampled on the falling edge.
    logic p_clk = 0, p_data = 0, p_le = 0, p_done = 0;
    int hi_run = 0, lo_run = 0, dat_run = 0, since_rise = 0, le_run = 0;
    int rise_cnt = 0, le_rise_cnt = 0;
    logic [7:0] sr = '0;
    logic [7:0] latched = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_clk = 0; p_data = 0; p_le = 0; p_done = 0;
            hi_run = 0; lo_run = 0; dat_run = 0; le_run = 0;
        end else begin
            if (atten_sclk && !p_clk) begin
                chk(lo_run == E_LOW, "R5 low phase", lo_run, E_LOW);
                chk(dat_run >= E_SETUP, "R7 data setup", dat_run, E_SETUP);
                chk(!atten_latch, "R3 latch at rising edge", atten_latch, 0);
                sr = {atten_sdata, sr[7:1]};
                rise_cnt++;
            end
            if (atten_sclk && p_clk)
                chk(atten_sdata == p_data, "R7 data hold", atten_sdata, p_data);
            if (!atten_sclk && p_clk)
                chk(hi_run == E_HIGH, "R5 high phase", hi_run, E_HIGH);
            if (atten_latch && !p_le) begin
                chk(since_rise == E_HIGH + E_LSU, "R6 latch setup", since_rise, E_HIGH + E_LSU);
                latched = sr;
                le_rise_cnt++;
            end
            if (!atten_latch && p_le) begin
                chk(le_run == E_LEW, "R6 latch width", le_run, E_LEW);
                chk(done == 1'b1, "R8 done with latch fall", done, 1);
            end
            if (done && p_done) chk(0, "R8 done width", 2, 1);

            // Run-length updates.
            hi_run = atten_sclk ? (p_clk ? hi_run + 1 : 1) : 0;
            if (atten_sclk) lo_run = 0;
            else if (!busy) lo_run = 0;
            else if (p_clk) lo_run = 1;
            else lo_run++;
            if (!busy) dat_run = 0;
            else if (atten_sdata != p_data) dat_run = 1;
            else dat_run++;
            since_rise = (atten_sclk && !p_clk) ? 1 : since_rise + 1;
            le_run = atten_latch ? (p_le ? le_run + 1 : 1) : 0;

            p_clk = atten_sclk; p_data = atten_sdata; p_le = atten_latch; p_done = done;
        end
    end

    task automatic run_xfer(input logic [5:0] r, input bit inject);
        int rb, lb, n;
        rb = rise_cnt;
        lb = le_rise_cnt;
        @(negedge clk);
        start = 1'b1;
        atten_req = r;
        @(negedge clk);
        start = 1'b0;
        atten_req = 6'($urandom);
        chk(busy == 1'b1, "R9 busy after start", busy, 1);
        chk(serial_sel == 1'b1, "R10 serial select", serial_sel, 1);
        n = 0;
        while (!done && n < 2000) begin
            if (inject && n == 30) begin
                start = 1'b1;
                atten_req = ~r;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(done == 1'b1, "R8 done reached", done, 1);
        chk(n == E_XFER, "R9 busy length", n, E_XFER);
        chk(latched == exp_word(r), "R1 word latched", latched, exp_word(r));
        chk(rise_cnt - rb == 8, "R2 rising edges", rise_cnt - rb, 8);
        chk(le_rise_cnt - lb == 1, "R4 latch pulses", le_rise_cnt - lb, 1);
        chk(busy == 1'b1, "R9 busy on done", busy, 1);
        @(negedge clk);
        chk(!done && !busy, "R9 idle after done", {done, busy}, 0);
        chk(!atten_sclk && !atten_latch && !atten_sdata, "R10 idle lines",
            {atten_sclk, atten_latch, atten_sdata}, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(!atten_sclk && !atten_latch && !atten_sdata && !busy && !done,
            "R10 reset outputs", {atten_sclk, atten_latch, atten_sdata, busy, done}, 0);
        chk(serial_sel == 1'b1, "R10 select in reset", serial_sel, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !atten_sclk, "R10 idle after reset", {busy, atten_sclk}, 0);

        run_xfer(6'd25, 1'b0);  // 12.5 dB -> 50
        run_xfer(6'd0, 1'b0);
        run_xfer(6'd63, 1'b0);  // 31.5 dB -> 126
        run_xfer(6'h2A, 1'b1);  // R9: start while busy ignored
        run_xfer(6'h15, 1'b1);
        for (int i = 0; i < 16; i++) begin
            repeat ($urandom_range(0, 5)) @(negedge clk);
            run_xfer(6'($urandom), ($urandom_range(0, 3) == 0));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule